// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache Controller

This block is a direct-mapped cache that holds one 32-bit word per line, together with the sequencer that drives it. It sits between a simple multicycle processor and a slow main memory whose accesses take a fixed number of cycles. Instruction fetches look up the line picked by the address index and compare its stored tag and valid flag. On a hit the word goes straight to the instruction output. On a miss the sequencer undoes its speculative program-counter step, reads the word from main memory, refills the line and replays the fetch, which then hits.

Stores do not check for a hit. They overwrite the indexed line (data, tag and valid) and write the same word through to main memory, and they stall for the whole memory write. The block owns the program counter and the instruction register. The processor starts one operation at a time with a single-cycle request and waits for the one-cycle `done` pulse.

The states, in `wtc_pkg::wtc_state_e`, are as follows:
- `S_IDLE` accepts a request. A store goes to `S_WR_ISSUE`; a fetch goes to `S_FETCH`.
- `S_FETCH` loads the instruction register and adds 4 to the PC. On a hit it goes back to `S_IDLE` with `done`; on a miss it goes to `S_ROLLBACK`.
- `S_ROLLBACK` subtracts 4 from the PC and goes to `S_RD_ISSUE`.
- `S_RD_ISSUE` raises the read strobe and goes to `S_RD_WAIT`.
- `S_RD_WAIT` repeats for MEM_LAT-1 cycles and then goes to `S_FILL`.
- `S_FILL` writes valid, tag and data into the line and goes back to `S_FETCH`.
- `S_WR_ISSUE` writes the line, raises the write strobe and goes to `S_WR_WAIT`.
- `S_WR_WAIT` repeats for MEM_LAT-1 cycles and then goes back to `S_IDLE` with `done`.

Top module: `wtc_cache`

## Requirements
- R1: An address splits as follows: the tag is bits ADDR_W-1 down to IDX_W+2, the line index is bits IDX_W+1 down to 2, and the two low bits are not used for lookup. Lines with different indices are independent, and a difference in the lowest tag bit alone gives a miss.
- R2: After reset, `busy`, `done`, `mem_rd`, `mem_wr`, `instr` and `pc_out` are all 0, and every line is invalid, so the first fetch to any index misses.
- R3: Take a fetch whose indexed line is valid and holds a matching tag (a hit). `done` rises 2 cycles after the request edge. `instr` then equals the cached word, `pc_out` equals `fetch_pc`+4, and there is no memory strobe.
- R4: Take a fetch miss. Exactly one read strobe is issued, in the 3rd cycle after the request edge, at the address `fetch_pc`. The memory word is captured MEM_LAT cycles later. `done` rises 10 cycles after the request (MEM_LAT=5), with `instr` equal to the memory word and `pc_out` equal to `fetch_pc`+4.
- R5: A refill always overwrites the indexed line. A later fetch of an older address that shares the index but has a different tag misses again.
- R6: A store writes the line without any hit check. It issues one write strobe in the 1st cycle after the request, carrying `store_addr` and `store_data`, and `done` rises 6 cycles after the request. A later fetch of that address hits and returns `store_data` with no read strobe.
- R7: Each strobe lasts one cycle. `mem_rd` and `mem_wr` are never high in the same cycle.
- R8: `busy` is high from the cycle after a request is accepted until the cycle before `done`, and low in the `done` cycle. Requests that arrive while `busy` is high are ignored.
- R9: When `store_req` and `fetch_req` arrive in the same idle cycle, the store is served and the fetch is dropped, so `pc_out` keeps its previous value.
- R10: The byte offset does not affect lookup. A fetch with non-zero low bits hits the word filled at offset 0, and `pc_out` equals that exact `fetch_pc`+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_req | input | 1 | Single-cycle fetch request, taken in idle |
| fetch_pc | input | ADDR_W | Byte address to fetch |
| store_req | input | 1 | Single-cycle store request, taken in idle |
| store_addr | input | ADDR_W | Store byte address |
| store_data | input | DATA_W | Store word |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| instr | output | DATA_W | Instruction register |
| pc_out | output | ADDR_W | Program counter |
| mem_addr | output | ADDR_W | Main-memory address |
| mem_rd | output | 1 | Read strobe, first cycle of a read |
| mem_wr | output | 1 | Write strobe, first cycle of a write |
| mem_wdata | output | DATA_W | Write data to main memory |
| mem_rdata | input | DATA_W | Read data from main memory |

## Verification
The assertions take for granted that main memory answers a read after exactly MEM_LAT cycles while `mem_addr` is held. They also assume the processor raises a request only in an idle cycle, apart from deliberate probes of the busy-ignore rule. The bench models memory as an arithmetic function of the word address, so `mem_rdata` is always ready at that latency. It raises each request for one cycle and waits for `done` before starting the next. The only request made while busy is a store injected during a refill wait, and the bench then checks that it had no effect at the ports.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_ROLLBACK,
        S_RD_ISSUE,
        S_RD_WAIT,
        S_FILL,
        S_WR_ISSUE,
        S_WR_WAIT
    } wtc_state_e;
endpackage

// File: rtl/wtc_array.sv
module wtc_array #(
    parameter int IDX_W  = 6,
    parameter int TAG_W  = 24,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [TAG_W-1:0]  rd_tag,
    output logic              hit,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int LINES = 1 << IDX_W;

    logic [LINES-1:0]  vld_q;
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] word_q [LINES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (wr_en) begin
            vld_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]  <= wr_tag;
            word_q[wr_idx] <= wr_data;
        end
    end

    assign hit     = vld_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
    assign rd_data = word_q[rd_idx];

    // R5: a written line reads back as valid with the written tag
    a_r5_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> vld_q[$past(wr_idx)] && tag_q[$past(wr_idx)] == $past(wr_tag));
endmodule

// File: rtl/wtc_fsm.sv
module wtc_fsm
    import wtc_pkg::*;
#(
    parameter int MEM_LAT = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fetch_req,
    input  logic       store_req,
    input  logic       hit,
    output wtc_state_e state,
    output logic       busy,
    output logic       done,
    output logic       take_fetch,
    output logic       take_store,
    output logic       ir_we,
    output logic       pc_inc,
    output logic       pc_dec,
    output logic       fill_we,
    output logic       st_we,
    output logic       mem_rd,
    output logic       mem_wr
);
    localparam int CNT_W = (MEM_LAT > 2) ? $clog2(MEM_LAT) : 1;
    localparam logic [CNT_W-1:0] WAIT_LOAD = CNT_W'(MEM_LAT - 2);

    wtc_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic done_q;
    logic wait_end;

    assign wait_end = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == S_FETCH && hit) || (state_q == S_WR_WAIT && wait_end);
            if (state_q == S_RD_ISSUE || state_q == S_WR_ISSUE) begin
                cnt_q <= WAIT_LOAD;
            end else if (!wait_end) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (store_req) state_d = S_WR_ISSUE;
                        else if (fetch_req) state_d = S_FETCH;
            S_FETCH:    state_d = hit ? S_IDLE : S_ROLLBACK;
            S_ROLLBACK: state_d = S_RD_ISSUE;
            S_RD_ISSUE: state_d = S_RD_WAIT;
            S_RD_WAIT:  if (wait_end) state_d = S_FILL;
            S_FILL:     state_d = S_FETCH;
            S_WR_ISSUE: state_d = S_WR_WAIT;
            S_WR_WAIT:  if (wait_end) state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    always_comb begin
        take_fetch = 1'b0;
        take_store = 1'b0;
        ir_we      = 1'b0;
        pc_inc     = 1'b0;
        pc_dec     = 1'b0;
        fill_we    = 1'b0;
        st_we      = 1'b0;
        mem_rd     = 1'b0;
        mem_wr     = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                take_store = store_req;
                take_fetch = fetch_req && !store_req;
            end
            S_FETCH: begin
                ir_we  = 1'b1;
                pc_inc = 1'b1;
            end
            S_ROLLBACK: pc_dec = 1'b1;
            S_RD_ISSUE: mem_rd = 1'b1;
            S_FILL:     fill_we = 1'b1;
            S_WR_ISSUE: begin
                st_we  = 1'b1;
                mem_wr = 1'b1;
            end
            default: ;
        endcase
    end

    assign state = state_q;
    assign busy  = (state_q != S_IDLE);
    assign done  = done_q;

    // R7: strobes are exclusive and last one cycle
    a_r7_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));
    a_r7_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);
    a_r7_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> !mem_wr);
    // R4: refill only follows the read wait chain
    a_r4_fill_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FILL) |-> $past(state_q) == S_RD_WAIT);
    // R8: an accepted request raises busy
    a_r8_busy_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (take_fetch || take_store) |=> busy);
endmodule

// File: rtl/wtc_cache.sv
module wtc_cache
    import wtc_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int IDX_W   = 6,
    parameter int MEM_LAT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] fetch_pc,
    input  logic              store_req,
    input  logic [ADDR_W-1:0] store_addr,
    input  logic [DATA_W-1:0] store_data,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] instr,
    output logic [ADDR_W-1:0] pc_out,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int OFS_W = 2;
    localparam int TAG_W = ADDR_W - IDX_W - OFS_W;
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

    wtc_state_e state;
    logic take_fetch, take_store, ir_we, pc_inc, pc_dec, fill_we, st_we, hit;
    logic [ADDR_W-1:0] pc_q, sa_q;
    logic [DATA_W-1:0] ir_q, sd_q, arr_word;
    logic store_path;

    wtc_fsm #(.MEM_LAT(MEM_LAT)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .fetch_req(fetch_req), .store_req(store_req), .hit(hit),
        .state(state), .busy(busy), .done(done),
        .take_fetch(take_fetch), .take_store(take_store),
        .ir_we(ir_we), .pc_inc(pc_inc), .pc_dec(pc_dec),
        .fill_we(fill_we), .st_we(st_we),
        .mem_rd(mem_rd), .mem_wr(mem_wr)
    );

    wtc_array #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_array (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(pc_q[IDX_W+OFS_W-1:OFS_W]),
        .rd_tag(pc_q[ADDR_W-1:IDX_W+OFS_W]),
        .hit(hit), .rd_data(arr_word),
        .wr_en(fill_we || st_we),
        .wr_idx(st_we ? sa_q[IDX_W+OFS_W-1:OFS_W] : pc_q[IDX_W+OFS_W-1:OFS_W]),
        .wr_tag(st_we ? sa_q[ADDR_W-1:IDX_W+OFS_W] : pc_q[ADDR_W-1:IDX_W+OFS_W]),
        .wr_data(st_we ? sd_q : mem_rdata)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
            ir_q <= '0;
            sa_q <= '0;
            sd_q <= '0;
        end else begin
            if (take_fetch)  pc_q <= fetch_pc;
            else if (pc_inc) pc_q <= pc_q + STEP;
            else if (pc_dec) pc_q <= pc_q - STEP;
            if (ir_we) ir_q <= arr_word;
            if (take_store) begin
                sa_q <= store_addr;
                sd_q <= store_data;
            end
        end
    end

    assign store_path = (state == S_WR_ISSUE) || (state == S_WR_WAIT);
    assign mem_addr   = store_path ? sa_q : pc_q;
    assign mem_wdata  = sd_q;
    assign instr      = ir_q;
    assign pc_out     = pc_q;

    // R4: the PC step taken in the fetch state is undone by rollback
    a_r4_rollback: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ROLLBACK) |=> pc_q == $past(pc_q) - STEP);
    // R4: the replayed fetch after a refill hits
    a_r4_refill_hits: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FILL) |=> hit);
    // R3: a hit completes in the next cycle and drops busy
    a_r3_hit_done: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FETCH && hit) |=> done && !busy);
    // R7: the address is held through a memory access
    a_r7_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RD_WAIT || state == S_WR_WAIT) |-> $stable(mem_addr));
endmodule

// File: tb/sim_wtc_cache.sv
`timescale 1ns/1ps
module sim_wtc_cache;
    localparam int AW = 32, DW = 32, IW = 4, LAT = 5;

    logic clk = 1'b0, rst_n = 1'b0;
    logic fetch_req = 0, store_req = 0;
    logic [AW-1:0] fetch_pc = 0, store_addr = 0;
    logic [DW-1:0] store_data = 0;
    logic busy, done, mem_rd, mem_wr;
    logic [DW-1:0] instr, mem_wdata, mem_rdata;
    logic [AW-1:0] pc_out, mem_addr;

    int total = 0, bad = 0, wd = 0;
    int lat, nrd, nwr, nbusy, nboth, rdcyc, wrcyc;
    logic [AW-1:0] rdaddr, wraddr;
    logic [DW-1:0] wrdata;

    always #2 clk = ~clk;

    function automatic logic [DW-1:0] memf(input logic [AW-1:0] a);
        return (a >> 2) * 32'h9E37_79B1 + 32'h0000_1357;
    endfunction

    assign mem_rdata = memf(mem_addr);

    wtc_cache #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(IW), .MEM_LAT(LAT)) u0 (
        .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_pc(fetch_pc),
        .store_req(store_req), .store_addr(store_addr), .store_data(store_data),
        .busy(busy), .done(done), .instr(instr), .pc_out(pc_out),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic op(input bit st, input bit fe, input logic [AW-1:0] fa,
                      input logic [AW-1:0] sadr, input logic [DW-1:0] sdat,
                      input bit poke, input logic [AW-1:0] padr);
        @(negedge clk);
        fetch_req = fe; fetch_pc = fa;
        store_req = st; store_addr = sadr; store_data = sdat;
        lat = 0; nrd = 0; nwr = 0; nbusy = 0; nboth = 0; rdcyc = 0; wrcyc = 0;
        do begin
            @(negedge clk);
            lat++;
            fetch_req = 0; store_req = 0;
            if (poke && lat == 4) begin
                store_req = 1; store_addr = padr; store_data = 32'hDEAD_0000;
            end
            if (mem_rd) begin nrd++; rdcyc = lat; rdaddr = mem_addr; end
            if (mem_wr) begin nwr++; wrcyc = lat; wraddr = mem_addr; wrdata = mem_wdata; end
            if (mem_rd && mem_wr) nboth++;
            if (busy) nbusy++;
        end while (!done && lat < 40);
        chk(nboth == 0, "R7 both strobes", nboth, 0);
    endtask

    task automatic fetch_miss(input logic [AW-1:0] a, input string req);
        op(0, 1, a, 0, 0, 0, 0);
        chk(lat == 10, {req, " miss latency"}, lat, 10);
        chk(nrd == 1 && rdcyc == 3, {req, " read strobe cycle"}, rdcyc, 3);
        chk(rdaddr == a, {req, " read address"}, rdaddr, a);
        chk(instr == memf(a), {req, " refill word"}, instr, memf(a));
        chk(pc_out == a + 4, {req, " pc after miss"}, pc_out, a + 4);
    endtask

    task automatic fetch_hit(input logic [AW-1:0] a, input logic [DW-1:0] w, input string req);
        op(0, 1, a, 0, 0, 0, 0);
        chk(lat == 2, {req, " hit latency"}, lat, 2);
        chk(nrd == 0 && nwr == 0, {req, " hit no strobe"}, nrd + nwr, 0);
        chk(instr == w, {req, " hit word"}, instr, w);
        chk(pc_out == a + 4, {req, " pc after hit"}, pc_out, a + 4);
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 100000) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected<100000", wd);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] a, b, sa, pprev;
        repeat (3) @(negedge clk);
        // R2 reset state
        chk(busy == 0 && done == 0, "R2 busy/done at reset", {busy, done}, 0);
        chk(mem_rd == 0 && mem_wr == 0, "R2 strobes at reset", {mem_rd, mem_wr}, 0);
        chk(instr == 0 && pc_out == 0, "R2 instr/pc at reset", instr | pc_out, 0);
        rst_n = 1;

        // R2 + R4: first fetch to every index misses; R8 busy window
        for (int i = 0; i < 16; i++) begin
            a = 32'h00C0_0000 | (i << 2);
            fetch_miss(a, "R2/R4");
            chk(nbusy == 9, "R8 busy cycles on miss", nbusy, 9);
        end
        // R1: every index kept independently; R3 hits; R10 offset ignored
        for (int i = 0; i < 16; i++) begin
            a = 32'h00C0_0000 | (i << 2);
            fetch_hit(a, memf(a), "R1/R3");
            chk(nbusy == 1, "R8 busy cycles on hit", nbusy, 1);
            fetch_hit(a | 3, memf(a), "R10");
        end
        // R1: lowest tag bit matters; R5: fixed replacement
        for (int i = 0; i < 16; i += 3) begin
            a = 32'h00C0_0000 | (i << 2);
            b = a ^ 32'h0000_0040;
            fetch_miss(b, "R1 tag bit");
            fetch_miss(a, "R5 evicted");
            fetch_hit(a, memf(a), "R5 refilled");
        end
        // R6: store overwrites without hit check, writes through
        for (int i = 0; i < 16; i += 5) begin
            sa = 32'h0200_0000 | (i << 2);
            op(1, 0, 0, sa, 32'hD000_0000 + i, 0, 0);
            chk(lat == 6, "R6 store latency", lat, 6);
            chk(nwr == 1 && wrcyc == 1 && nrd == 0, "R6 write strobe", wrcyc, 1);
            chk(wraddr == sa, "R6 write address", wraddr, sa);
            chk(wrdata == 32'hD000_0000 + i, "R6 write data", wrdata, 32'hD000_0000 + i);
            chk(nbusy == 5, "R8 busy cycles on store", nbusy, 5);
            fetch_hit(sa, 32'hD000_0000 + i, "R6 store then fetch");
        end
        // R9: simultaneous requests serve the store only
        pprev = pc_out;
        op(1, 1, 32'h0300_0010, 32'h0400_0020, 32'hBEEF_0001, 0, 0);
        chk(lat == 6 && nrd == 0 && nwr == 1, "R9 store wins", lat, 6);
        chk(pc_out == pprev, "R9 fetch dropped", pc_out, pprev);
        fetch_hit(32'h0400_0020, 32'hBEEF_0001, "R9 store landed");
        // R8: store request while busy is ignored
        op(0, 1, 32'h0500_0004, 0, 0, 1, 32'h0600_0008);
        chk(nwr == 0 && lat == 10, "R8 ignored while busy", nwr, 0);
        fetch_miss(32'h0600_0008, "R8 ignored store left no line");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule